// File: doc/BRIEF.md
# Microprocessor Supervisory Reset and Watchdog Controller

This block keeps a processor in reset while its supply is out of range and for a fixed settling time afterwards. It also watches a heartbeat signal from the software. A flag from an external undervoltage comparator, the heartbeat input, a heartbeat-disable indication, a period-select input and an active-low chip-enable all arrive as plain digital signals. A one-cycle tick, nominally one millisecond, sets the time base.

The supply flag and the heartbeat pass through a synchronizer first. While the flag is active, reset is held, the low-line output is low and the chip-enable output is forced inactive. This stops a memory from being written while the rails collapse. Once the flag clears, reset stays asserted for a further `RST_TICKS` ticks.

A heartbeat edge in either direction restarts the watchdog timer. If no edge arrives within the current period, the watchdog output drops and a reset pulse of `RST_TICKS` ticks is fired. The first period after any reset or timeout is always the long one. After the software has serviced the timer once, the select input chooses the short or the long period. A heartbeat that stays silent therefore causes one reset pulse per long period.

Top module: `mpu_supervisor`

## Requirements
- R1: While the synchronized supply flag is active, `rst_n_o` is low. It goes low no later than `SYNC_STAGES` clock cycles after `supply_low_i` rises.
- R2: After power-on reset is released, and again after the supply flag clears, `rst_n_o` stays low until exactly `RST_TICKS` ticks have occurred. It then goes high.
- R3: `rst_o` is always the logical inverse of `rst_n_o`.
- R4: Both a rising and a falling heartbeat edge restart the watchdog period. Edges spaced less than one period apart never cause a timeout.
- R5: On a timeout, `wdo_n_o` goes low and `rst_n_o` goes low. Reset is then held for `RST_TICKS` ticks. `wdo_n_o` stays low until the next heartbeat edge.
- R6: While the heartbeat stays silent, a new timeout reset occurs every `WD_LONG_TICKS` ticks.
- R7: While `wd_float_i` is 1, the watchdog produces no timeout and no reset, however long the heartbeat stays silent.
- R8: The first period after power-on, after the supply recovers, or after a timeout is `WD_LONG_TICKS`, whatever the selection. After a heartbeat edge, `wd_short_sel_i`=1 selects `WD_SHORT_TICKS` and 0 selects `WD_LONG_TICKS`.
- R9: A heartbeat edge returns `wdo_n_o` high. While the low-line condition is active, `wdo_n_o` is high.
- R10: `low_line_n_o` is low while the synchronized supply flag is active and high otherwise.
- R11: While the supply is good, `ce_out_n_o` equals `ce_in_n_i`. While `low_line_n_o` is low, `ce_out_n_o` is 1 (inactive).
- R12: While `por_n` is low, the outputs are `rst_n_o`=0, `rst_o`=1 and `wdo_n_o`=1, and the watchdog count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-cycle time-base enable |
| supply_low_i | input | 1 | Undervoltage flag from the comparator, asynchronous |
| wd_in_i | input | 1 | Heartbeat from software, asynchronous |
| wd_float_i | input | 1 | 1 disables the watchdog |
| wd_short_sel_i | input | 1 | 1 selects the short period after service |
| ce_in_n_i | input | 1 | Chip-enable request, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wdo_n_o | output | 1 | Watchdog expired, active low |
| low_line_n_o | output | 1 | Undervoltage indication, active low |
| ce_out_n_o | output | 1 | Gated chip-enable, active low |

## Verification
The properties assume that `tick_i` is a single-cycle pulse. They also assume that `wd_float_i` and `wd_short_sel_i` change slowly compared with the clock. The release of reset is tied to a preceding tick, and the timeout logic samples the disable input directly. The stimulus separates ticks by idle cycles and changes heartbeat, disable and select inputs only between ticks. It waits longer than the synchronizer depth before judging any response, so every synchronized value has settled when the checks sample it.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // Period choice used by the watchdog timer.
   typedef enum logic {
      WD_PER_LONG  = 1'b0,
      WD_PER_SHORT = 1'b1
   } wd_per_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] stage_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) stage_q <= RST_VAL;
            else         stage_q <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) stage_q <= {STAGES{RST_VAL}};
            else         stage_q <= {stage_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen #(
   parameter int RST_TICKS = 200,
   localparam int RW       = $clog2(RST_TICKS + 1)
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   input  logic hold,
   input  logic trig,
   output logic rst_act
);

   localparam logic [RW-1:0] RELOAD = RW'(RST_TICKS);

   logic [RW-1:0] remain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         remain_q <= RELOAD;
      end else if (hold || trig) begin
         remain_q <= RELOAD;
      end else if (tick && (remain_q != '0)) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign rst_act = hold | (remain_q != '0);

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
   import sup_pkg::*;
#(
   parameter int LONG_TICKS  = 1600,
   parameter int SHORT_TICKS = 100,
   localparam int WW         = $clog2(LONG_TICKS + 1)
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   input  logic wd_lvl,
   input  logic disable_i,
   input  logic short_sel,
   input  logic hold,
   output logic edge_o,
   output logic timeout_o,
   output logic wdo_n
);

   localparam logic [WW-1:0] LONG_LAST  = WW'(LONG_TICKS - 1);
   localparam logic [WW-1:0] SHORT_LAST = WW'(SHORT_TICKS - 1);

   logic          prev_q;
   logic          first_q;
   logic          wdo_n_q;
   logic [WW-1:0] cnt_q;
   logic [WW-1:0] last_val;
   logic          active;
   wd_per_e       per_sel;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) prev_q <= 1'b0;
      else         prev_q <= wd_lvl;
   end

   assign edge_o = wd_lvl ^ prev_q;
   assign active = !disable_i && !hold;

   always_comb begin
      if (!first_q && short_sel) per_sel = WD_PER_SHORT;
      else                       per_sel = WD_PER_LONG;
   end

   assign last_val  = (per_sel == WD_PER_SHORT) ? SHORT_LAST : LONG_LAST;
   assign timeout_o = active && !edge_o && tick && (cnt_q >= last_val);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
         wdo_n_q <= 1'b1;
      end else if (!active) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
         wdo_n_q <= 1'b1;
      end else if (edge_o) begin
         cnt_q   <= '0;
         first_q <= 1'b0;
         wdo_n_q <= 1'b1;
      end else if (timeout_o) begin
         cnt_q   <= '0;
         first_q <= 1'b1;
         wdo_n_q <= 1'b0;
      end else if (tick) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign wdo_n = wdo_n_q;

endmodule

// File: rtl/mpu_supervisor.sv
module mpu_supervisor #(
   parameter int SYNC_STAGES    = 2,
   parameter int RST_TICKS      = 200,
   parameter int WD_LONG_TICKS  = 1600,
   parameter int WD_SHORT_TICKS = 100
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick_i,
   input  logic supply_low_i,
   input  logic wd_in_i,
   input  logic wd_float_i,
   input  logic wd_short_sel_i,
   input  logic ce_in_n_i,
   output logic rst_n_o,
   output logic rst_o,
   output logic wdo_n_o,
   output logic low_line_n_o,
   output logic ce_out_n_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (RST_TICKS < 1) begin : g_bad_rst
         $error("RST_TICKS must be at least 1");
      end
      if (WD_SHORT_TICKS < 2) begin : g_bad_short
         $error("WD_SHORT_TICKS must be at least 2");
      end
      if (WD_LONG_TICKS <= WD_SHORT_TICKS) begin : g_bad_long
         $error("WD_LONG_TICKS must exceed WD_SHORT_TICKS");
      end
      if (WD_LONG_TICKS <= RST_TICKS) begin : g_bad_ratio
         $error("WD_LONG_TICKS must exceed RST_TICKS");
      end
   endgenerate

   logic low_q;
   logic wd_q;
   logic wd_edge;
   logic wd_timeout;
   logic rst_act;

   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_low (
      .clk    (clk),
      .arst_n (por_n),
      .d      (supply_low_i),
      .q      (low_q)
   );

   sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wd (
      .clk    (clk),
      .arst_n (por_n),
      .d      (wd_in_i),
      .q      (wd_q)
   );

   sup_wdog #(.LONG_TICKS(WD_LONG_TICKS), .SHORT_TICKS(WD_SHORT_TICKS)) u_wdog (
      .clk       (clk),
      .arst_n    (por_n),
      .tick      (tick_i),
      .wd_lvl    (wd_q),
      .disable_i (wd_float_i),
      .short_sel (wd_short_sel_i),
      .hold      (low_q),
      .edge_o    (wd_edge),
      .timeout_o (wd_timeout),
      .wdo_n     (wdo_n_o)
   );

   sup_rst_gen #(.RST_TICKS(RST_TICKS)) u_rst (
      .clk     (clk),
      .arst_n  (por_n),
      .tick    (tick_i),
      .hold    (low_q),
      .trig    (wd_timeout),
      .rst_act (rst_act)
   );

   assign rst_n_o      = ~rst_act;
   assign rst_o        = rst_act;
   assign low_line_n_o = ~low_q;
   assign ce_out_n_o   = low_q | ce_in_n_i;

endmodule

// File: rtl/sup_checker.sv
module sup_checker (
   input logic clk,
   input logic por_n,
   input logic tick_i,
   input logic low_q,
   input logic wd_float_i,
   input logic wd_edge,
   input logic wd_timeout,
   input logic rst_n_o,
   input logic wdo_n_o,
   input logic low_line_n_o,
   input logic ce_out_n_o
);

   AST_LOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!por_n)
      low_q |-> !rst_n_o); // R1

   AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_n_o) |-> $past(tick_i)); // R2

   AST_TIMEOUT_RESETS: assert property (@(posedge clk) disable iff (!por_n)
      wd_timeout |=> (!rst_n_o && !wdo_n_o)); // R5

   AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      wd_float_i |-> !wd_timeout); // R7

   AST_EDGE_RAISES_WDO: assert property (@(posedge clk) disable iff (!por_n)
      (wd_edge && !wd_float_i && !low_q) |=> wdo_n_o); // R9

   AST_LOWLINE_WDO_HIGH: assert property (@(posedge clk) disable iff (!por_n)
      !low_line_n_o |=> wdo_n_o); // R9

   AST_CE_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
      !low_line_n_o |-> ce_out_n_o); // R11

endmodule

bind mpu_supervisor sup_checker u_sup_checker (
   .clk          (clk),
   .por_n        (por_n),
   .tick_i       (tick_i),
   .low_q        (low_q),
   .wd_float_i   (wd_float_i),
   .wd_edge      (wd_edge),
   .wd_timeout   (wd_timeout),
   .rst_n_o      (rst_n_o),
   .wdo_n_o      (wdo_n_o),
   .low_line_n_o (low_line_n_o),
   .ce_out_n_o   (ce_out_n_o)
);

// File: tb/tb_mpu_supervisor.sv
`timescale 1ns/1ps
module tb_mpu_supervisor;

   localparam int RST   = 4;
   localparam int LONG  = 20;
   localparam int SHORT = 6;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic tick_i = 1'b0;
   logic supply_low_i = 1'b0;
   logic wd_in_i = 1'b0;
   logic wd_float_i = 1'b0;
   logic wd_short_sel_i = 1'b1;
   logic ce_in_n_i = 1'b0;
   logic rst_n_o, rst_o, wdo_n_o, low_line_n_o, ce_out_n_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mpu_supervisor #(
      .SYNC_STAGES(2), .RST_TICKS(RST),
      .WD_LONG_TICKS(LONG), .WD_SHORT_TICKS(SHORT)
   ) dut (
      .clk(clk), .por_n(por_n), .tick_i(tick_i), .supply_low_i(supply_low_i),
      .wd_in_i(wd_in_i), .wd_float_i(wd_float_i), .wd_short_sel_i(wd_short_sel_i),
      .ce_in_n_i(ce_in_n_i), .rst_n_o(rst_n_o), .rst_o(rst_o), .wdo_n_o(wdo_n_o),
      .low_line_n_o(low_line_n_o), .ce_out_n_o(ce_out_n_o)
   );

   task automatic chk(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", what, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_i = 1'b1;
         @(negedge clk) tick_i = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic toggle_wd();
      @(negedge clk) wd_in_i = ~wd_in_i;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_por_state();
      repeat (3) @(negedge clk);
      chk("R12 rst_n in por", rst_n_o, 1'b0);
      chk("R3 rst_o in por", rst_o, 1'b1);
      chk("R12 wdo_n in por", wdo_n_o, 1'b1);
      chk("R10 low_line_n good supply", low_line_n_o, 1'b1);
      chk("R11 ce follows 0", ce_out_n_o, 1'b0);
      @(negedge clk) por_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_por_release();
      ticks(RST - 1);
      chk("R2 held before last tick", rst_n_o, 1'b0);
      ticks(1);
      chk("R2 released after RST ticks", rst_n_o, 1'b1);
      chk("R3 rst_o inverse after release", rst_o, 1'b0);
   endtask

   task automatic t_first_long_and_repeat();
      ticks(LONG - RST - 1);
      chk("R8 first period long despite short select", rst_n_o, 1'b1);
      chk("R8 wdo_n high before long period", wdo_n_o, 1'b1);
      ticks(1);
      chk("R5 timeout wdo_n low", wdo_n_o, 1'b0);
      chk("R5 timeout asserts reset", rst_n_o, 1'b0);
      ticks(RST - 1);
      chk("R5 pulse still held", rst_n_o, 1'b0);
      ticks(1);
      chk("R5 pulse ends after RST ticks", rst_n_o, 1'b1);
      chk("R5 wdo_n stays low", wdo_n_o, 1'b0);
      ticks(LONG - RST - 1);
      chk("R6 no repeat before long period", rst_n_o, 1'b1);
      ticks(1);
      chk("R6 repeated timeout reset", rst_n_o, 1'b0);
      ticks(RST);
   endtask

   task automatic t_service_short();
      toggle_wd();
      chk("R9 edge raises wdo_n", wdo_n_o, 1'b1);
      for (int k = 0; k < 4; k++) begin
         ticks(SHORT - 1);
         toggle_wd();
      end
      chk("R4 both edges restart, no reset", rst_n_o, 1'b1);
      chk("R4 both edges restart, wdo_n high", wdo_n_o, 1'b1);
      ticks(SHORT - 1);
      chk("R8 short period not yet expired", rst_n_o, 1'b1);
      ticks(1);
      chk("R8 short period expired wdo_n", wdo_n_o, 1'b0);
      ticks(RST);
      toggle_wd();
   endtask

   task automatic t_long_select();
      wd_short_sel_i = 1'b0;
      toggle_wd();
      ticks(SHORT);
      chk("R8 long select ignores short length", rst_n_o, 1'b1);
      ticks(LONG - SHORT - 1);
      chk("R8 long select before expiry", wdo_n_o, 1'b1);
      ticks(1);
      chk("R8 long select expiry", wdo_n_o, 1'b0);
      ticks(RST);
      toggle_wd();
   endtask

   task automatic t_float();
      wd_float_i = 1'b1;
      ticks(3 * LONG);
      chk("R7 disabled no reset", rst_n_o, 1'b1);
      chk("R7 disabled wdo_n high", wdo_n_o, 1'b1);
      wd_float_i = 1'b0;
      toggle_wd();
   endtask

   task automatic t_supply_low();
      wd_short_sel_i = 1'b1;
      toggle_wd();
      ticks(SHORT);
      chk("R5 wdo_n low before supply drop", wdo_n_o, 1'b0);
      ticks(RST);
      ce_in_n_i = 1'b0;
      @(negedge clk) supply_low_i = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 reset within sync latency", rst_n_o, 1'b0);
      chk("R10 low_line_n low", low_line_n_o, 1'b0);
      chk("R11 ce forced inactive", ce_out_n_o, 1'b1);
      @(negedge clk);
      chk("R9 wdo_n high during low line", wdo_n_o, 1'b1);
      ticks(RST + 2);
      chk("R1 reset held while low", rst_n_o, 1'b0);
      @(negedge clk) supply_low_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 low_line_n returns high", low_line_n_o, 1'b1);
      chk("R11 ce follows after recovery", ce_out_n_o, 1'b0);
      ce_in_n_i = 1'b1;
      @(negedge clk);
      chk("R11 ce follows 1", ce_out_n_o, 1'b1);
      ticks(RST - 1);
      chk("R2 held after supply recovery", rst_n_o, 1'b0);
      ticks(1);
      chk("R2 released after supply recovery", rst_n_o, 1'b1);
      chk("R3 rst_o follows", rst_o, 1'b0);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      t_por_state();
      t_por_release();
      t_first_long_and_repeat();
      t_service_short();
      t_long_select();
      t_float();
      t_supply_low();
      summary();
      $finish;
   end

endmodule